// File: doc/BRIEF.md
# Single-Bit and Scaled-Address Unit

A purely combinational execute-stage unit for a 64-bit integer core. It handles two groups of operations. The first group works on one bit of the source word: set it, clear it, flip it, or extract it. The second group forms addresses by shifting one operand left by 1, 2 or 3 and adding the other.

The address group also has unsigned-word forms. These take only the low 32 bits of the first operand, zero-extended, before the shift or add. A related form places the low 32 bits of the source at a bit position and drops anything that would go past bit 63.

The bit index comes either from the low bits of the second operand or from an immediate field, chosen by a select input. Each group has its own enable. The unsigned-word forms need 64-bit mode. The unit flags any request it cannot legally perform and forces the result to zero in that case.

Top module: `bitaddr_unit`

## Requirements
- R1: Operation code 0 (set) returns the source with bit `idx` forced to 1 and every other bit unchanged.
- R2: Operation code 1 (clear) returns the source with bit `idx` forced to 0 and every other bit unchanged.
- R3: Operation code 2 (invert) returns the source with bit `idx` complemented and every other bit unchanged.
- R4: Operation code 3 (extract) returns bit `idx` of the source in result bit 0, with result bits 63..1 all zero.
- R5: When `use_imm` is 1 the index is `imm_idx`; when it is 0 the index is `src_b[5:0]`. The result does not depend on the index source that is not selected.
- R6: When `mode64` is 1 the index uses 6 bits. When `mode64` is 0 only the low 5 bits of the selected index are used, so the index is taken modulo 32.
- R7: Operation codes 4, 5 and 6 return `(src_a << N) + src_b` modulo 2^64, with N = 1, 2 and 3 respectively.
- R8: Operation codes 7, 8 and 9 return `(zext(src_a[31:0]) << N) + src_b` modulo 2^64, with N = 1, 2 and 3 respectively.
- R9: Operation code 10 returns `zext(src_a[31:0]) + src_b` modulo 2^64.
- R10: Operation code 11 returns `zext(src_a[31:0])` shifted left by the 6-bit index. Zeros fill the vacated bits, and bits shifted past bit 63 are lost.
- R11: Operation codes 7 to 11 raise `illegal` when `mode64` is 0.
- R12: Operation codes 0 to 3 raise `illegal` when `en_single` is 0. Operation codes 4 to 11 raise `illegal` when `en_addr` is 0. Each enable has no effect on the other group.
- R13: Operation codes 12 to 15 always raise `illegal`. Whenever `illegal` is 1, `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second operand; its low 6 bits are the register-form index |
| imm_idx | input | 6 | Immediate bit index or shift amount |
| use_imm | input | 1 | 1 selects `imm_idx` as the index |
| op_sel | input | 4 | Operation code (see requirements) |
| mode64 | input | 1 | 1 when running in 64-bit mode |
| en_single | input | 1 | Enable for the single-bit group |
| en_addr | input | 1 | Enable for the address group |
| result | output | 64 | Operation result, zero when illegal |
| illegal | output | 1 | Request cannot be performed |

## Verification
Random operands are run through every operation code, and the unit is compared with a bench model that builds masks bit by bit and scales by multiplication.

Directed cases place the index at 0, 31, 32 and 63. In 32-bit mode these separate a 6-bit index from a modulo-32 index.

Operands with all-ones upper halves show whether the unsigned-word forms really discard bits 63..32 of `src_a`. Large shift amounts in code 11 expose bits that should have been dropped past bit 63.

Sweeps of the enable and mode inputs, paired with each operation group, check that each enable gates only its own group. Changing the index source that is not selected checks that it has no effect.

// File: rtl/bitaddr_pkg.sv
package bitaddr_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned IDXW = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_SET    = 4'd0,
    OP_CLR    = 4'd1,
    OP_INV    = 4'd2,
    OP_EXT    = 4'd3,
    OP_SC1    = 4'd4,
    OP_SC2    = 4'd5,
    OP_SC3    = 4'd6,
    OP_SC1_W  = 4'd7,
    OP_SC2_W  = 4'd8,
    OP_SC3_W  = 4'd9,
    OP_ADD_W  = 4'd10,
    OP_SLL_W  = 4'd11
  } op_e;

  function automatic logic [XLEN-1:0] f_onehot(input logic [IDXW-1:0] idx);
    logic [XLEN-1:0] one;
    one = {{(XLEN-1){1'b0}}, 1'b1};
    return one << idx;
  endfunction

  function automatic logic [XLEN-1:0] f_zext_low(input logic [XLEN-1:0] a);
    return {{(XLEN-HALF){1'b0}}, a[HALF-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] f_place_low(input logic [XLEN-1:0] a,
                                                  input logic [IDXW-1:0] sh);
    return f_zext_low(a) << sh;
  endfunction
endpackage

// File: rtl/bitaddr_decode.sv
module bitaddr_decode
  import bitaddr_pkg::*;
(
  input  logic [3:0] op_sel,
  input  logic       mode64,
  input  logic       en_single,
  input  logic       en_addr,
  output logic       is_single,
  output logic       is_scaled,
  output logic       is_place,
  output logic       is_word,
  output logic [1:0] scale,
  output logic [1:0] bit_kind,
  output logic       illegal
);
  logic reserved;

  always_comb begin
    is_single = 1'b0;
    is_scaled = 1'b0;
    is_place  = 1'b0;
    is_word   = 1'b0;
    scale     = 2'd0;
    bit_kind  = op_sel[1:0];
    reserved  = 1'b0;
    case (op_sel)
      OP_SET, OP_CLR, OP_INV, OP_EXT: is_single = 1'b1;
      OP_SC1: begin is_scaled = 1'b1; scale = 2'd1; end
      OP_SC2: begin is_scaled = 1'b1; scale = 2'd2; end
      OP_SC3: begin is_scaled = 1'b1; scale = 2'd3; end
      OP_SC1_W: begin is_scaled = 1'b1; is_word = 1'b1; scale = 2'd1; end
      OP_SC2_W: begin is_scaled = 1'b1; is_word = 1'b1; scale = 2'd2; end
      OP_SC3_W: begin is_scaled = 1'b1; is_word = 1'b1; scale = 2'd3; end
      OP_ADD_W: begin is_scaled = 1'b1; is_word = 1'b1; scale = 2'd0; end
      OP_SLL_W: begin is_place = 1'b1; is_word = 1'b1; end
      default: reserved = 1'b1;
    endcase
    illegal = reserved
            | (is_single & ~en_single)
            | ((is_scaled | is_place) & ~en_addr)
            | (is_word & ~mode64);
  end

  always_comb begin
    if (is_word && !mode64)
      a_r11_word_needs_mode64: assert (illegal);
    if (op_sel >= 4'd12)
      a_r13_reserved_illegal: assert (illegal);
  end
endmodule

// File: rtl/bit_single_ops.sv
module bit_single_ops
  import bitaddr_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    kind,
  output logic [W-1:0]  res
);
  logic [W-1:0] mask;
  logic [W-1:0] shifted;

  assign mask    = {{(W-1){1'b0}}, 1'b1} << idx;
  assign shifted = src >> idx;

  always_comb begin
    case (kind)
      2'd0:    res = src | mask;
      2'd1:    res = src & ~mask;
      2'd2:    res = src ^ mask;
      default: res = {{(W-1){1'b0}}, shifted[0]};
    endcase
  end

  always_comb begin
    if (kind != 2'd3)
      a_r3_single_bit_touched: assert ($countones(res ^ src) <= 1);
    if (kind == 2'd3)
      a_r4_extract_upper_zero: assert (res[W-1:1] == '0);
  end
endmodule

// File: rtl/scaled_adder.sv
module scaled_adder
  import bitaddr_pkg::*;
#(
  parameter int unsigned W      = XLEN,
  parameter int unsigned MAXSH  = 3,
  localparam int unsigned SW    = $clog2(MAXSH + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          word,
  input  logic [SW-1:0] scale,
  output logic [W-1:0]  sum
);
  logic [W-1:0] opa;
  logic [W-1:0] cand [MAXSH+1];

  assign opa = word ? {{(W-W/2){1'b0}}, a[W/2-1:0]} : a;

  for (genvar k = 0; k <= int'(MAXSH); k++) begin : g_scale
    assign cand[k] = (opa << k) + b;
  end

  always_comb begin
    sum = cand[0];
    for (int k = 0; k <= int'(MAXSH); k++)
      if (scale == SW'(k)) sum = cand[k];
  end
endmodule

// File: rtl/bitaddr_unit.sv
module bitaddr_unit
  import bitaddr_pkg::*;
(
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [5:0]  imm_idx,
  input  logic        use_imm,
  input  logic [3:0]  op_sel,
  input  logic        mode64,
  input  logic        en_single,
  input  logic        en_addr,
  output logic [63:0] result,
  output logic        illegal
);
  localparam int unsigned NARROW = $clog2(HALF);

  logic            is_single, is_scaled, is_place, is_word;
  logic [1:0]      scale, bit_kind;
  logic [IDXW-1:0] raw_idx, eff_idx;
  logic [XLEN-1:0] single_res, scaled_res, place_res;

  bitaddr_decode dec_i (
    .op_sel(op_sel), .mode64(mode64), .en_single(en_single), .en_addr(en_addr),
    .is_single(is_single), .is_scaled(is_scaled), .is_place(is_place),
    .is_word(is_word), .scale(scale), .bit_kind(bit_kind), .illegal(illegal)
  );

  assign raw_idx = use_imm ? imm_idx : src_b[IDXW-1:0];
  assign eff_idx = mode64 ? raw_idx
                          : {{(IDXW-NARROW){1'b0}}, raw_idx[NARROW-1:0]};

  bit_single_ops #(.W(XLEN)) bits_i (
    .src(src_a), .idx(eff_idx), .kind(bit_kind), .res(single_res)
  );

  scaled_adder #(.W(XLEN), .MAXSH(3)) adder_i (
    .a(src_a), .b(src_b), .word(is_word), .scale(scale), .sum(scaled_res)
  );

  assign place_res = f_place_low(src_a, eff_idx);

  always_comb begin
    if (illegal)        result = '0;
    else if (is_single) result = single_res;
    else if (is_scaled) result = scaled_res;
    else if (is_place)  result = place_res;
    else                result = '0;
  end

  always_comb begin
    if (illegal)
      a_r13_illegal_zero: assert (result == '0);
    if (!illegal && is_place && eff_idx != '0)
      a_r10_place_low_clear: assert ((result & (f_onehot(eff_idx) - 64'd1)) == '0);
    if (!illegal && op_sel == OP_SET)
      a_r1_set_bit_high: assert (result[eff_idx] == 1'b1);
    if (!illegal && op_sel == OP_CLR)
      a_r2_clear_bit_low: assert (result[eff_idx] == 1'b0);
  end
endmodule

// File: tb/bitaddr_unit_tb_top.sv
module bitaddr_unit_tb_top;
  logic        clk = 1'b0;
  logic [63:0] src_a, src_b;
  logic [5:0]  imm_idx;
  logic        use_imm, mode64, en_single, en_addr;
  logic [3:0]  op_sel;
  logic [63:0] result;
  logic        illegal;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bitaddr_unit dut_i (
    .src_a(src_a), .src_b(src_b), .imm_idx(imm_idx), .use_imm(use_imm),
    .op_sel(op_sel), .mode64(mode64), .en_single(en_single), .en_addr(en_addr),
    .result(result), .illegal(illegal)
  );

  function automatic int ref_idx();
    int i;
    i = use_imm ? int'(imm_idx) : int'(src_b[5:0]);
    if (!mode64) i = i % 32;
    return i;
  endfunction

  function automatic bit ref_illegal();
    int o = int'(op_sel);
    if (o >= 12) return 1;
    if (o <= 3) return !en_single;
    if (!en_addr) return 1;
    if (o >= 7 && !mode64) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] ref_result();
    logic [63:0] m, lo, r;
    int i, o;
    i = ref_idx();
    o = int'(op_sel);
    m = '0;
    for (int k = 0; k < 64; k++) if (k == i) m[k] = 1'b1;
    lo = src_a & 64'h0000_0000_FFFF_FFFF;
    r = '0;
    if (ref_illegal()) return '0;
    case (o)
      0: r = src_a | m;
      1: r = src_a & ~m;
      2: r = src_a ^ m;
      3: r = {63'd0, src_a[i]};
      4, 5, 6: r = src_a * (64'd1 << (o - 3)) + src_b;
      7, 8, 9: r = lo * (64'd1 << (o - 6)) + src_b;
      10: r = lo + src_b;
      11: for (int k = 0; k < 32; k++) if (k + i < 64) r[k + i] = src_a[k];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag);
    logic [63:0] exp_r;
    bit exp_i;
    #2;
    exp_r = ref_result();
    exp_i = ref_illegal();
    n_run++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_fail++;
      $display("FAIL %s op=%0d: result=%h illegal=%0b expected result=%h illegal=%0b",
               tag, op_sel, result, illegal, exp_r, exp_i);
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] imm, input logic ui, input logic m64,
                       input logic es, input logic ea);
    op_sel = op; src_a = a; src_b = b; imm_idx = imm; use_imm = ui;
    mode64 = m64; en_single = es; en_addr = ea;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    drive(4'd0, '0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R1 idle inputs");
    // Directed index boundaries across single-bit ops
    for (int op = 0; op < 4; op++) begin
      drive(4'(op), 64'hA5A5_0F0F_F0F0_5A5A, 64'd0, 6'd63, 1'b1, 1'b1, 1'b1, 1'b1);
      check(op == 0 ? "R1 idx63" : op == 1 ? "R2 idx63" : op == 2 ? "R3 idx63" : "R4 idx63");
      drive(4'(op), 64'hFFFF_FFFF_0000_0001, 64'd32, 6'd0, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R5 register index 32");
      drive(4'(op), 64'hFFFF_FFFF_0000_0001, 64'd32, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      check("R6 modulo 32 index");
      drive(4'(op), 64'h8000_0000_8000_0000, 64'd0, 6'd31, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R6 index 31 narrow");
    end
    // Unselected index source has no effect
    drive(4'd2, 64'h0, 64'd5, 6'd40, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 imm selected");
    drive(4'd2, 64'h0, 64'd17, 6'd40, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 b ignored");
    // Unsigned-word forms discard upper half of src_a
    for (int op = 7; op <= 10; op++) begin
      drive(4'(op), 64'hFFFF_FFFF_8000_0003, 64'h10, 6'd0, 1'b0, 1'b1, 1'b1, 1'b1);
      check(op == 10 ? "R9 add word" : "R8 scaled word");
    end
    drive(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 6'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R7 wraparound");
    drive(4'd11, 64'hDEAD_BEEF_F00D_CAFE, 64'd0, 6'd63, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10 shift 63 drops");
    drive(4'd11, 64'hDEAD_BEEF_F00D_CAFE, 64'd0, 6'd40, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10 shift 40");
    drive(4'd9, 64'h1234, 64'h1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 word op in 32-bit mode");
    drive(4'd4, 64'h1234, 64'h1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 plain scaled fine in 32-bit mode");
    drive(4'd1, 64'hFF, 64'h1, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R12 single disabled");
    drive(4'd5, 64'hFF, 64'h1, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R12 addr unaffected by single enable");
    drive(4'd5, 64'hFF, 64'h1, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R12 addr disabled");
    drive(4'd3, 64'hFF, 64'h1, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R12 single unaffected by addr enable");
    for (int op = 12; op < 16; op++) begin
      drive(4'(op), 64'hFFFF, 64'hFFFF, 6'd3, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R13 reserved code");
    end
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      drive(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
            6'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
            ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0));
      check("R1-R13 random mix");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule